// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between a 16-bit internal bus master and the external memory bus. It accepts one transfer request at a time. The request can be a word or a byte, a read or a write. The chip-select decoder supplies three things with each request: the port width of the target, a wait-state count, and a flag that marks an on-chip register hit. From these the block runs the external bus cycles and returns a single acknowledge with the read data.

When a word transfer targets an 8-bit port, the block runs two byte cycles back to back. Both bytes travel on the upper data lane. The block drives the least-significant address bit itself, 0 for the first byte and 1 for the second. The address strobe and the selected data strobe stay asserted from the first clock of the first byte cycle to the last clock of the second. On a read, the first byte is placed in the upper half of the returned word and the second byte in the lower half. On a write, the first byte sent is `wdata_i[15:8]` and the second is `wdata_i[7:0]`.

A transfer to a 16-bit port, or to an address that no chip-select claims (reported by the decoder as a 16-bit port), takes one access. A hit on an on-chip register never reaches the external bus and is acknowledged in the next cycle.

Top module: `dbs_seq`

## Requirements
- R1: While reset is active, and whenever no transfer is in progress, `as_o`, `uds_o`, `lds_o`, `we_o` and `ack_o` are all low.
- R2: A word transfer with `port8_i`=0 runs one external cycle with `as_o`, `uds_o` and `lds_o` high. `ext_addr_o` equals `addr_i` with bit 0 forced to 0. Write data appears on all 16 bits of `ext_dout_o`, and a read returns `ext_din_i` unchanged.
- R3: A word transfer with `port8_i`=1 runs exactly two byte cycles. `ext_addr_o[0]` is 0 in the first and 1 in the second, and the upper address bits do not change. `as_o` and `uds_o` stay high without a gap across both cycles, and `lds_o` stays low.
- R4: On an 8-bit port write, each byte is driven on `ext_dout_o[15:8]` and `ext_dout_o[7:0]` is 0. In a split write the first byte is `wdata_i[15:8]` and the second is `wdata_i[7:0]`.
- R5: In a split read, the byte taken from `ext_din_i[15:8]` in the first cycle returns in `rdata_o[15:8]`, and the byte taken in the second cycle returns in `rdata_o[7:0]`.
- R6: A byte transfer with `port8_i`=1 is a single cycle with `ext_addr_o[0]` = `addr_i[0]`, and only `as_o` and `uds_o` are high. The byte travels on lane [15:8]. On a write the byte comes from `wdata_i[15:8]` for an even address and from `wdata_i[7:0]` for an odd one. On a read the byte returns in `rdata_o[15:8]` for an even address and in `rdata_o[7:0]` for an odd one; the other half is 0.
- R7: A byte transfer with `port8_i`=0 uses the natural lane: an even address selects `uds_o` and lane [15:8], an odd address selects `lds_o` and lane [7:0]. The unused lane is 0 on writes and 0 in `rdata_o` on reads.
- R8: Every external cycle lasts `wait_i`+1 clocks, as captured when the request is accepted. Read data is sampled on the last clock of each cycle.
- R9: A request with `int_hit_i`=1 raises no strobe. `ack_o` rises in the next cycle, and on a read `rdata_o` equals `int_rdata_i`.
- R10: `req_i` is a one-cycle start pulse accepted only while the block is idle. A pulse during a transfer, together with any change of the request and decoder inputs at that time, has no effect on that transfer.
- R11: `ack_o` is a one-clock pulse, given once per accepted request, in the clock after the last clock of the final cycle. All strobes are low while `ack_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start pulse from the master |
| we_i | input | 1 | 1 = write, 0 = read |
| word_i | input | 1 | 1 = 16-bit transfer, 0 = byte |
| addr_i | input | AW | Byte address |
| wdata_i | input | 16 | Write data; even byte in [15:8], odd byte in [7:0] |
| port8_i | input | 1 | Decoder: target port is 8 bits wide |
| wait_i | input | WW | Decoder: wait states per cycle |
| int_hit_i | input | 1 | Decoder: on-chip register access |
| int_rdata_i | input | 16 | On-chip register read data |
| ack_o | output | 1 | Completion pulse to the master |
| rdata_o | output | 16 | Read data, valid with `ack_o` |
| as_o | output | 1 | External address strobe |
| uds_o | output | 1 | Upper data strobe (lane [15:8]) |
| lds_o | output | 1 | Lower data strobe (lane [7:0]) |
| we_o | output | 1 | External write enable |
| ext_addr_o | output | AW | External address with generated bit 0 |
| ext_dout_o | output | 16 | External write data |
| ext_din_i | input | 16 | External read data |

## Verification
A wait-state counter that loads the wrong value, or a half flag that fails to advance, changes the length of the strobe window or the value of `ext_addr_o[0]`. It also moves the `ack_o` pulse by at least one clock. Each of these shows on the first cycle of the first transfer that exercises it. A steering or gathering fault leaves the strobes correct but puts the wrong byte on `ext_dout_o[15:8]` during that same byte cycle. On a read it shows as a swapped or zeroed half of `rdata_o`, which appears in the acknowledge cycle. Because the outputs are compared against an expected value on every clock, a held strobe that drops between the two halves of a split transfer shows up in the first clock it is missing.

// File: rtl/dbs_pkg.sv
`timescale 1ns/1ps
package dbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_DONE = 2'd2
  } dbs_state_e;

  typedef struct packed {
    logic        we;
    logic        word;
    logic        port8;
    logic [15:0] wdata;
  } dbs_req_t;
endpackage

// File: rtl/dbs_wait_cnt.sv
`timescale 1ns/1ps
module dbs_wait_cnt #(
  parameter int WW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [WW-1:0] load_val_i,
  input  logic          en_i,
  output logic          last_o
);
  logic [WW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (en_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/dbs_wr_steer.sv
`timescale 1ns/1ps
module dbs_wr_steer (
  input  logic        drive_i,
  input  logic        port8_i,
  input  logic        word_i,
  input  logic        a0_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] dout_o
);
  logic [7:0] byte_sel;

  // in a split transfer a0 tracks the half, so one select covers both cases
  assign byte_sel = a0_i ? wdata_i[7:0] : wdata_i[15:8];

  always_comb begin
    dout_o = '0;
    if (drive_i) begin
      if (port8_i)     dout_o = {byte_sel, 8'h00};
      else if (word_i) dout_o = wdata_i;
      else if (a0_i)   dout_o = {8'h00, wdata_i[7:0]};
      else             dout_o = {wdata_i[15:8], 8'h00};
    end
  end
endmodule

// File: rtl/dbs_rd_gather.sv
`timescale 1ns/1ps
module dbs_rd_gather (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        int_cap_i,
  input  logic [15:0] int_data_i,
  input  logic        cap_i,
  input  logic        port8_i,
  input  logic        word_i,
  input  logic        a0_i,
  input  logic [15:0] din_i,
  output logic [15:0] rdata_o
);
  logic [15:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
    end else if (int_cap_i) begin
      rd_q <= int_data_i;
    end else if (clr_i) begin
      rd_q <= '0;
    end else if (cap_i) begin
      if (port8_i) begin
        if (a0_i) rd_q[7:0]  <= din_i[15:8];
        else      rd_q[15:8] <= din_i[15:8];
      end else if (word_i) begin
        rd_q <= din_i;
      end else if (a0_i) begin
        rd_q[7:0] <= din_i[7:0];
      end else begin
        rd_q[15:8] <= din_i[15:8];
      end
    end
  end

  assign rdata_o = rd_q;
endmodule

// File: rtl/dbs_seq.sv
`timescale 1ns/1ps
module dbs_seq
  import dbs_pkg::*;
#(
  parameter int AW = 24,
  parameter int WW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          word_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   wdata_i,
  input  logic          port8_i,
  input  logic [WW-1:0] wait_i,
  input  logic          int_hit_i,
  input  logic [15:0]   int_rdata_i,
  output logic          ack_o,
  output logic [15:0]   rdata_o,
  output logic          as_o,
  output logic          uds_o,
  output logic          lds_o,
  output logic          we_o,
  output logic [AW-1:0] ext_addr_o,
  output logic [15:0]   ext_dout_o,
  input  logic [15:0]   ext_din_i
);
  localparam int UPPER_W = AW - 1;

  dbs_state_e      st_q;
  dbs_req_t        rq_q;
  logic [AW-1:0]   addr_q;
  logic [WW-1:0]   wait_q;
  logic            half_q;

  logic idle, in_acc, accept, split, last, a0, next_half;

  assign idle      = (st_q == ST_IDLE);
  assign in_acc    = (st_q == ST_ACC);
  assign accept    = idle && req_i;
  assign split     = rq_q.port8 && rq_q.word;
  assign next_half = in_acc && last && split && !half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rq_q   <= '0;
      addr_q <= '0;
      wait_q <= '0;
      half_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          rq_q   <= '{we: we_i, word: word_i, port8: port8_i, wdata: wdata_i};
          addr_q <= addr_i;
          wait_q <= wait_i;
          half_q <= 1'b0;
          st_q   <= int_hit_i ? ST_DONE : ST_ACC;
        end
        ST_ACC: if (last) begin
          if (split && !half_q) half_q <= 1'b1;
          else                  st_q   <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  dbs_wait_cnt #(.WW(WW)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept || next_half),
    .load_val_i (accept ? wait_i : wait_q),
    .en_i       (in_acc),
    .last_o     (last)
  );

  // generated A0: half index when split, 0 for word, request bit for byte
  assign a0 = split ? half_q : (rq_q.word ? 1'b0 : addr_q[0]);

  dbs_wr_steer u_wr (
    .drive_i (in_acc && rq_q.we),
    .port8_i (rq_q.port8),
    .word_i  (rq_q.word),
    .a0_i    (a0),
    .wdata_i (rq_q.wdata),
    .dout_o  (ext_dout_o)
  );

  dbs_rd_gather u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (accept),
    .int_cap_i  (accept && int_hit_i && !we_i),
    .int_data_i (int_rdata_i),
    .cap_i      (in_acc && last && !rq_q.we),
    .port8_i    (rq_q.port8),
    .word_i     (rq_q.word),
    .a0_i       (a0),
    .din_i      (ext_din_i),
    .rdata_o    (rdata_o)
  );

  logic [UPPER_W-1:0] upper_addr;
  assign upper_addr = addr_q[AW-1:1];

  assign ack_o      = (st_q == ST_DONE);
  assign as_o       = in_acc;
  assign uds_o      = in_acc && (rq_q.port8 || rq_q.word || !a0);
  assign lds_o      = in_acc && !rq_q.port8 && (rq_q.word || a0);
  assign we_o       = in_acc && rq_q.we;
  assign ext_addr_o = {upper_addr, a0};
endmodule

// File: rtl/dbs_seq_chk.sv
`timescale 1ns/1ps
module dbs_seq_chk #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          idle_i,
  input logic          req_i,
  input logic          int_hit_i,
  input logic          ack_o,
  input logic          as_o,
  input logic          uds_o,
  input logic          lds_o,
  input logic          we_o,
  input logic [AW-1:0] ext_addr_o,
  input logic [15:0]   ext_dout_o
);
  // R1
  strobe_needs_as_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uds_o || lds_o || we_o) |-> as_o);

  // R3
  a0_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_o && $past(as_o)) |-> !($past(ext_addr_o[0]) && !ext_addr_o[0]));

  // R3
  upper_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_o && $past(as_o)) |-> $stable(ext_addr_o[AW-1:1]));

  // R4
  low_lane_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (as_o && we_o && !lds_o) |-> (ext_dout_o[7:0] == 8'h00));

  // R9
  int_hit_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && req_i && int_hit_i) |=> (ack_o && !as_o));

  // R11
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R11
  ack_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !(as_o || uds_o || lds_o));

  // R11
  as_drop_to_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(as_o) |-> ack_o);
endmodule

bind dbs_seq dbs_seq_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .idle_i     (idle),
  .req_i      (req_i),
  .int_hit_i  (int_hit_i),
  .ack_o      (ack_o),
  .as_o       (as_o),
  .uds_o      (uds_o),
  .lds_o      (lds_o),
  .we_o       (we_o),
  .ext_addr_o (ext_addr_o),
  .ext_dout_o (ext_dout_o)
);

// File: tb/dbs_seq_bench.sv
`timescale 1ns/1ps
module dbs_seq_bench;
  localparam int AW = 24;
  localparam int WW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, word = 1'b0, port8 = 1'b0, int_hit = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0, int_rdata = '0;
  logic [WW-1:0] wait_n = '0;
  logic          ack, as_s, uds, lds, we_x;
  logic [15:0]   rdata, dout, din;
  logic [AW-1:0] eaddr;

  always #4 clk = ~clk;

  function automatic logic [15:0] mem_f(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[8:1] ^ 8'h3C};
  endfunction

  assign din = mem_f(eaddr);

  dbs_seq #(.AW(AW), .WW(WW)) u_dbs_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .word_i(word),
    .addr_i(addr), .wdata_i(wdata), .port8_i(port8), .wait_i(wait_n),
    .int_hit_i(int_hit), .int_rdata_i(int_rdata), .ack_o(ack), .rdata_o(rdata),
    .as_o(as_s), .uds_o(uds), .lds_o(lds), .we_o(we_x), .ext_addr_o(eaddr),
    .ext_dout_o(dout), .ext_din_i(din)
  );

  typedef struct {
    logic          as_e, uds_e, lds_e, we_e, ack_e, chk_rd;
    logic [AW-1:0] addr_e;
    logic [15:0]   dout_e, rd_e;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0;
  int   fails = 0;
  bit   done = 0;

  function automatic exp_t idle_e(input string tag);
    exp_t e;
    e.as_e = 0; e.uds_e = 0; e.lds_e = 0; e.we_e = 0; e.ack_e = 0; e.chk_rd = 0;
    e.addr_e = '0; e.dout_e = '0; e.rd_e = '0; e.tag = tag;
    return e;
  endfunction

  task automatic miss(input string tag, input string what, input logic [31:0] act, input logic [31:0] expv);
    fails++;
    $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, expv, $time);
  endtask

  always @(negedge clk) begin
    if (!done) begin
      exp_t e;
      vectors++;
      if (!rst_n) e = idle_e("R1");
      else if (exp_q.size() > 0) e = exp_q.pop_front();
      else e = idle_e("R1");
      if (as_s !== e.as_e)  miss(e.tag, "as",  {31'd0, as_s}, {31'd0, e.as_e});
      if (uds  !== e.uds_e) miss(e.tag, "uds", {31'd0, uds},  {31'd0, e.uds_e});
      if (lds  !== e.lds_e) miss(e.tag, "lds", {31'd0, lds},  {31'd0, e.lds_e});
      if (ack  !== e.ack_e) miss(e.tag, "ack", {31'd0, ack},  {31'd0, e.ack_e});
      if (we_x !== (e.as_e && e.we_e)) miss(e.tag, "we", {31'd0, we_x}, {31'd0, e.as_e && e.we_e});
      if (e.as_e && eaddr !== e.addr_e) miss(e.tag, "addr", {8'd0, eaddr}, {8'd0, e.addr_e});
      if (e.as_e && e.we_e && dout !== e.dout_e) miss(e.tag, "dout", {16'd0, dout}, {16'd0, e.dout_e});
      if (e.ack_e && e.chk_rd && rdata !== e.rd_e) miss(e.tag, "rdata", {16'd0, rdata}, {16'd0, e.rd_e});
    end
  end

  task automatic txn(input string tag, input bit t_we, input bit t_word, input bit t_p8,
                     input bit t_int, input int t_wait, input logic [AW-1:0] t_addr,
                     input logic [15:0] t_wd, input logic [15:0] t_ird, input bit poke);
    exp_t e;
    logic [15:0] rd_acc = '0;
    int halves;
    bit sp;
    @(posedge clk); #2;
    req = 1; we = t_we; word = t_word; port8 = t_p8; int_hit = t_int;
    wait_n = WW'(t_wait); addr = t_addr; wdata = t_wd; int_rdata = t_ird;
    exp_q.push_back(idle_e(tag));
    if (!t_int) begin
      sp = t_p8 && t_word;
      halves = sp ? 2 : 1;
      for (int h = 0; h < halves; h++) begin
        logic a0b;
        logic [15:0] m;
        a0b = sp ? h[0] : (t_word ? 1'b0 : t_addr[0]);
        e = idle_e(tag);
        e.as_e = 1; e.we_e = t_we;
        e.addr_e = {t_addr[AW-1:1], a0b};
        e.uds_e = t_p8 || t_word || !t_addr[0];
        e.lds_e = !t_p8 && (t_word || t_addr[0]);
        m = mem_f(e.addr_e);
        if (t_p8) begin
          e.dout_e = {(a0b ? t_wd[7:0] : t_wd[15:8]), 8'h00};
          if (a0b) rd_acc[7:0] = m[15:8]; else rd_acc[15:8] = m[15:8];
        end else if (t_word) begin
          e.dout_e = t_wd; rd_acc = m;
        end else if (t_addr[0]) begin
          e.dout_e = {8'h00, t_wd[7:0]}; rd_acc[7:0] = m[7:0];
        end else begin
          e.dout_e = {t_wd[15:8], 8'h00}; rd_acc[15:8] = m[15:8];
        end
        for (int k = 0; k <= t_wait; k++) exp_q.push_back(e);
      end
    end else begin
      rd_acc = t_ird;
    end
    e = idle_e(tag);
    e.ack_e = 1; e.chk_rd = !t_we; e.rd_e = rd_acc;
    exp_q.push_back(e);
    @(posedge clk); #2;
    if (poke) begin
      // R10: stray request with altered inputs during the transfer
      req = 1; addr = t_addr ^ 24'h00055B; port8 = !t_p8; word = !t_word;
      we = !t_we; int_hit = !t_int; wait_n = WW'(t_wait + 5); wdata = ~t_wd;
      int_rdata = ~t_ird;
      @(posedge clk); #2;
    end
    req = 0;
    while (exp_q.size() > 0) @(negedge clk);
    @(posedge clk);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    repeat (3) @(posedge clk);
    // R2: 16-bit port word, no wait / with wait
    txn("R2", 1, 1, 0, 0, 0, 24'h001234, 16'hBEEF, 16'h0, 0);
    txn("R2", 0, 1, 0, 0, 2, 24'h00A010, 16'h0, 16'h0, 0);
    // R3 R4: split writes
    txn("R3", 1, 1, 1, 0, 0, 24'h004440, 16'hC35A, 16'h0, 0);
    txn("R4", 1, 1, 1, 0, 3, 24'h0077FE, 16'h1299, 16'h0, 0);
    // R5: split reads
    txn("R5", 0, 1, 1, 0, 1, 24'h0100A2, 16'h0, 16'h0, 0);
    txn("R5", 0, 1, 1, 0, 0, 24'h00FFF6, 16'h0, 16'h0, 0);
    // R6: byte on 8-bit port
    txn("R6", 1, 0, 1, 0, 0, 24'h002000, 16'hA1B2, 16'h0, 0);
    txn("R6", 1, 0, 1, 0, 1, 24'h002001, 16'hA1B2, 16'h0, 0);
    txn("R6", 0, 0, 1, 0, 0, 24'h002106, 16'h0, 16'h0, 0);
    txn("R6", 0, 0, 1, 0, 2, 24'h002107, 16'h0, 16'h0, 0);
    // R7: byte on 16-bit port
    txn("R7", 1, 0, 0, 0, 0, 24'h003010, 16'h5566, 16'h0, 0);
    txn("R7", 1, 0, 0, 0, 0, 24'h003011, 16'h5566, 16'h0, 0);
    txn("R7", 0, 0, 0, 0, 1, 24'h003020, 16'h0, 16'h0, 0);
    txn("R7", 0, 0, 0, 0, 0, 24'h003021, 16'h0, 16'h0, 0);
    // R8: longest wait on a split read
    txn("R8", 0, 1, 1, 0, 15, 24'h0050C0, 16'h0, 16'h0, 0);
    // R9: on-chip register hit
    txn("R9", 0, 1, 0, 1, 7, 24'hFFF100, 16'h0, 16'h7E81, 0);
    txn("R9", 1, 1, 1, 1, 3, 24'hFFF102, 16'h1111, 16'h0, 0);
    // R10: stray request ignored
    txn("R10", 0, 1, 1, 0, 1, 24'h006600, 16'h0, 16'h0, 1);
    txn("R10", 1, 1, 0, 0, 0, 24'h006700, 16'hABCD, 16'h0, 1);
    txn("R10", 0, 0, 0, 1, 0, 24'hFFF0F0, 16'h0, 16'h2468, 1);
    // R11: mixed sweep, ack placement checked each clock
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 24'h013579 + 24'h000100);
      txn("R11", i[0], i[1], i[2], (i % 7) == 3, i % 5, a, 16'(i * 16'h2F1D),
          16'(i * 16'h0B07), (i % 9) == 4);
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule